// File: doc/BRIEF.md
# Radio Message Time Stamp Encoder

This block computes the 6-bit time stamp field that goes with each message on a radio transport link. The field is encoded in one of three ways, chosen by the message kind. Antenna-carrier sample messages carry a running sequence number that restarts at every radio frame boundary. Ethernet segments carry packet position flags, and the last segment also carries a byte count. Generic packet segments carry position flags and an address extension.

The encoder sits next to the message assembler. In every cycle where the assembler presents a message, it also presents the kind, the segment position flags, the Ethernet byte count and the address extension. The time stamp is ready combinationally in that same cycle. The only state inside the block is the sample sequence counter and the held address extension.

Top module: `msg_tstamp_gen`

## Requirements
- R1: For a sample message (msgKind 2'b00) with no frame boundary in the same cycle, tstamp equals the number of sample messages seen since the last clear, and each such message adds one.
- R2: frameEdge clears the sample sequence. A sample message in the same cycle as frameEdge gets tstamp 0, and the next sample message gets 1. After a frameEdge with no message, the next sample message gets 0.
- R3: The sample sequence wraps from 63 to 0 when no frame boundary has cleared it.
- R4: An Ethernet message (msgKind 2'b01) with segStart=1 and segEnd=0 gets 6'b100000. One with neither flag set gets 6'b000000.
- R5: An Ethernet message with segEnd=1 gets tstamp = {1'b1, ethBytes[4:0]}.
- R6: A generic packet message (msgKind 2'b10) carries flags in tstamp[5:4]: 2'b10 for start, 2'b00 for middle, 2'b11 for end.
- R7: For generic packets, tstamp[3:0] is addrExt as sampled on the start segment. Middle and end segments repeat the held value and ignore the addrExt input.
- R8: A segment with both segStart and segEnd set is encoded as an end segment. For generic packets it uses the addrExt input of that cycle.
- R9: tstamp is 0 when msgValid is low or when msgKind is 2'b11. Only sample messages advance the sequence.
- R10: After reset the sequence is 0 and the held extension is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEdge | input | 1 | Radio frame boundary strobe |
| msgValid | input | 1 | A message is present this cycle |
| msgKind | input | 2 | 00 sample, 01 Ethernet, 10 generic, 11 reserved |
| segStart | input | 1 | Segment is the first of its packet |
| segEnd | input | 1 | Segment is the last of its packet |
| ethBytes | input | 5 | Frame bytes in the Ethernet end segment payload |
| addrExt | input | 4 | Generic packet address extension |
| tstamp | output | 6 | Encoded time stamp, valid with msgValid |

## Verification
A wrong sequence counter shows up on the first sample message after the fault: its tstamp is off by a constant amount, and that offset stays until the next frame boundary clears it. Clear or wrap faults therefore appear within one message of the boundary or of the 63rd message. A wrong held extension shows on the low nibble of the next generic middle or end segment. A misrouted format select shows in the same cycle as the message.

// File: rtl/msg_ts_pkg.sv
package msg_ts_pkg;
  typedef enum logic [1:0] {
    KIND_SAMPLE  = 2'b00,
    KIND_ETH     = 2'b01,
    KIND_GENERIC = 2'b10,
    KIND_RSVD    = 2'b11
  } msgKindT;

  typedef enum logic [2:0] {
    FMT_ZERO,
    FMT_COUNT,
    FMT_ETH_START,
    FMT_ETH_END,
    FMT_GEN
  } fmtSelT;

  typedef struct packed {
    logic       cntClear;
    logic       cntAdvance;
    logic       extLoad;
    logic       extBypass;
    logic [1:0] genFlags;
    fmtSelT     fmt;
  } tsCtrlT;
endpackage

// File: rtl/msg_ts_ctrl.sv
module msg_ts_ctrl
  import msg_ts_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameEdge,
  input  logic       msgValid,
  input  logic [1:0] msgKind,
  input  logic       segStart,
  input  logic       segEnd,
  output tsCtrlT     ctrl
);
  msgKindT kind;
  assign kind = msgKindT'(msgKind);

  always_comb begin
    ctrl            = '0;
    ctrl.fmt        = FMT_ZERO;
    ctrl.cntClear   = frameEdge;
    if (msgValid) begin
      unique case (kind)
        KIND_SAMPLE: begin
          ctrl.cntAdvance = 1'b1;
          // a boundary in the same cycle wins: stamp is zero
          ctrl.fmt = frameEdge ? FMT_ZERO : FMT_COUNT;
        end
        KIND_ETH: begin
          if (segEnd)        ctrl.fmt = FMT_ETH_END;
          else if (segStart) ctrl.fmt = FMT_ETH_START;
          else               ctrl.fmt = FMT_ZERO;
        end
        KIND_GENERIC: begin
          ctrl.fmt       = FMT_GEN;
          ctrl.extLoad   = segStart;
          ctrl.extBypass = segStart;
          if (segEnd)        ctrl.genFlags = 2'b11;
          else if (segStart) ctrl.genFlags = 2'b10;
          else               ctrl.genFlags = 2'b00;
        end
        default: ctrl.fmt = FMT_ZERO;
      endcase
    end
  end

  // R9: nothing advances or loads without a message
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |-> (!ctrl.cntAdvance && !ctrl.extLoad && ctrl.fmt == FMT_ZERO));

  // R8: end flag dominates start for generic packets
  p_end_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && kind == KIND_GENERIC && segEnd) |-> ctrl.genFlags == 2'b11);
endmodule

// File: rtl/msg_ts_datapath.sv
module msg_ts_datapath
  import msg_ts_pkg::*;
#(
  parameter int TsWidth  = 6,
  parameter int ExtWidth = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tsCtrlT               ctrl,
  input  logic [TsWidth-2:0]   ethBytes,
  input  logic [ExtWidth-1:0]  addrExt,
  output logic [TsWidth-1:0]   tstamp
);
  localparam int FlagWidth = TsWidth - ExtWidth;
  localparam logic [TsWidth-1:0] TopBit = TsWidth'(1) << (TsWidth - 1);

  logic [TsWidth-1:0]  seqCnt;
  logic [ExtWidth-1:0] extHeld;
  logic [ExtWidth-1:0] extUse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt  <= '0;
      extHeld <= '0;
    end else begin
      if (ctrl.cntAdvance)
        seqCnt <= ctrl.cntClear ? TsWidth'(1) : seqCnt + TsWidth'(1);
      else if (ctrl.cntClear)
        seqCnt <= '0;
      if (ctrl.extLoad)
        extHeld <= addrExt;
    end
  end

  assign extUse = ctrl.extBypass ? addrExt : extHeld;

  always_comb begin
    unique case (ctrl.fmt)
      FMT_COUNT:     tstamp = seqCnt;
      FMT_ETH_START: tstamp = TopBit;
      FMT_ETH_END:   tstamp = {1'b1, ethBytes};
      FMT_GEN:       tstamp = {ctrl.genFlags[FlagWidth-1:0], extUse};
      default:       tstamp = '0;
    endcase
  end

  // R3: the sequence rolls over to zero after its top value
  p_seq_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntAdvance && !ctrl.cntClear && seqCnt == '1) |=> seqCnt == '0);

  // R7: held extension only moves on a start segment
  p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.extLoad |=> $stable(extHeld));
endmodule

// File: rtl/msg_tstamp_gen.sv
module msg_tstamp_gen
  import msg_ts_pkg::*;
#(
  parameter int TsWidth  = 6,
  parameter int ExtWidth = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameEdge,
  input  logic                msgValid,
  input  logic [1:0]          msgKind,
  input  logic                segStart,
  input  logic                segEnd,
  input  logic [TsWidth-2:0]  ethBytes,
  input  logic [ExtWidth-1:0] addrExt,
  output logic [TsWidth-1:0]  tstamp
);
  tsCtrlT ctrl;

  msg_ts_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .frameEdge(frameEdge), .msgValid(msgValid),
    .msgKind(msgKind), .segStart(segStart), .segEnd(segEnd), .ctrl(ctrl)
  );

  msg_ts_datapath #(.TsWidth(TsWidth), .ExtWidth(ExtWidth)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .ethBytes(ethBytes),
    .addrExt(addrExt), .tstamp(tstamp)
  );

  logic sampleMsg;
  assign sampleMsg = msgValid && msgKind == 2'b00;

  // R2: boundary with a sample message stamps zero
  p_edge_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleMsg && frameEdge) |-> tstamp == '0);

  // R1: back-to-back sample messages step by one
  p_seq_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleMsg && !frameEdge) ##1 (sampleMsg && !frameEdge)
      |-> tstamp == $past(tstamp) + TsWidth'(1));

  // R4: Ethernet middle segment is all zero
  p_eth_mid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind == 2'b01 && !segStart && !segEnd) |-> tstamp == '0);

  // R5: Ethernet end segment has the top bit set
  p_eth_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind == 2'b01 && segEnd) |-> tstamp[TsWidth-1]);

  // R9: silent output without a message
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |-> tstamp == '0);
endmodule

// File: tb/test_msg_tstamp_gen.sv
module test_msg_tstamp_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameEdge = 1'b0, msgValid = 1'b0, segStart = 1'b0, segEnd = 1'b0;
  logic [1:0] msgKind = 2'b00;
  logic [4:0] ethBytes = '0;
  logic [3:0] addrExt = '0;
  logic [5:0] tstamp;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [5:0] expQ[$];
  string      tagQ[$];
  logic [5:0] mCnt = '0;
  logic [3:0] mExt = '0;

  always #2.5 clk = ~clk;

  msg_tstamp_gen i_msg_tstamp_gen (
    .clk(clk), .rstN(rstN), .frameEdge(frameEdge), .msgValid(msgValid),
    .msgKind(msgKind), .segStart(segStart), .segEnd(segEnd),
    .ethBytes(ethBytes), .addrExt(addrExt), .tstamp(tstamp)
  );

  task automatic send(input logic fe, input logic v, input logic [1:0] k,
                      input logic s, input logic e, input logic [4:0] nb,
                      input logic [3:0] ext, input string tag);
    logic [5:0] exp;
    @(negedge clk);
    frameEdge = fe; msgValid = v; msgKind = k; segStart = s; segEnd = e;
    ethBytes = nb; addrExt = ext;
    exp = '0;
    if (v && k == 2'b00) begin
      exp  = fe ? 6'd0 : mCnt;
      mCnt = fe ? 6'd1 : mCnt + 6'd1;
    end else begin
      if (fe) mCnt = '0;
      if (v && k == 2'b01)
        exp = e ? {1'b1, nb} : (s ? 6'b100000 : 6'b000000);
      else if (v && k == 2'b10) begin
        if (s) mExt = ext;
        exp = {(e ? 2'b11 : (s ? 2'b10 : 2'b00)), mExt};
      end
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    send(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 5'd0, 4'd0, "R9 idle");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [5:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (tstamp !== e) begin
          fails++;
          $display("FAIL %s: tstamp=%b expected=%b", t, tstamp, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: first sample after reset is zero
    send(0, 1, 2'b00, 0, 0, 0, 0, "R10 reset sequence");
    for (int i = 0; i < 4; i++) send(0, 1, 2'b00, 0, 0, 0, 0, "R1 step");
    // R9: other kinds do not advance the sequence
    send(0, 1, 2'b01, 1, 0, 0, 0, "R4 eth start");
    send(0, 1, 2'b11, 1, 1, 5'd9, 4'd7, "R9 reserved kind");
    send(0, 1, 2'b00, 0, 0, 0, 0, "R9 no advance");
    idle();
    // R2: boundary alone, then boundary with message
    send(1, 0, 2'b00, 0, 0, 0, 0, "R2 edge alone");
    send(0, 1, 2'b00, 0, 0, 0, 0, "R2 after edge");
    send(0, 1, 2'b00, 0, 0, 0, 0, "R2 after edge step");
    send(1, 1, 2'b00, 0, 0, 0, 0, "R2 edge with msg");
    send(0, 1, 2'b00, 0, 0, 0, 0, "R2 next after edge");
    // R3: run past 63
    for (int i = 0; i < 70; i++) send(0, 1, 2'b00, 0, 0, 0, 0, "R3 wrap");
    // R4 / R5: Ethernet packet
    send(0, 1, 2'b01, 1, 0, 5'd3, 0, "R4 eth start");
    send(0, 1, 2'b01, 0, 0, 5'd3, 0, "R4 eth middle");
    send(0, 1, 2'b01, 0, 1, 5'd31, 0, "R5 eth end 31");
    send(0, 1, 2'b01, 0, 1, 5'd0, 0, "R5 eth end 0");
    // R6 / R7: generic packet, input extension changes mid-packet
    send(0, 1, 2'b10, 1, 0, 0, 4'd9, "R6 gen start");
    send(0, 1, 2'b10, 0, 0, 0, 4'd3, "R7 gen middle held");
    send(0, 1, 2'b10, 0, 1, 0, 4'd5, "R7 gen end held");
    // R8: single-segment packets
    send(0, 1, 2'b01, 1, 1, 5'd7, 0, "R8 eth single");
    send(0, 1, 2'b10, 1, 1, 0, 4'd6, "R8 gen single");
    send(0, 1, 2'b10, 0, 0, 0, 4'd1, "R7 held after single");
    idle();
    idle();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule